// File: doc/BRIEF.md
# Frame Timing Sequencer

This block is the central controller of a time-division-duplexing waveform engine. Once enabled, it waits for a one-cycle sync pulse. It then counts out an optional startup delay and plays a run of frames. Within each frame, a counter sweeps from zero to a programmed frame length. Downstream channel logic compares its own switch points against this counter value, and uses the frame-start and frame-end strobes to mark frame edges.

The sequence either stops after a programmed number of frames or repeats until the enable bit is cleared. A mode bit decides what happens when a sync arrives in the middle of a sequence: either it is ignored, or it restarts the counter at zero.

The startup delay, frame length and burst count are held in shadow registers. Software loads them through a plain write strobe, and a write is taken only while the engine is disabled. All pins are plain control and status signals. No data streams through the block, so it has no valid/ready handshake.

Top module: `tdd_frame_seq`

## Requirements
- R1: `state_o` reports the phase with the code IDLE=0, ARMED=1, WAITING=2, RUNNING=3. After reset the outputs are IDLE, a count of 0 and both strobes low.
- R2: With `enable` high, IDLE moves to ARMED on the next clock. A sync pulse seen in IDLE is ignored. ARMED holds until a sync pulse arrives.
- R3: A sync pulse in ARMED enters WAITING with count 0. WAITING lasts max(D,1) cycles, where D is the startup delay, and the count shows 0,1,... during it. After that, RUNNING starts with count 0, so a delay of 0 costs exactly one cycle.
- R4: In RUNNING, the count steps 0,1,...,L, where L is the frame length. It then wraps to 0, so one frame lasts L+1 cycles and frames follow back to back.
- R5: `frame_start_o` is high exactly when RUNNING with count 0. `frame_end_o` is high exactly when RUNNING with count L, except in a cycle where a sync restart is taken.
- R6: With a burst count B>0, the block returns to IDLE with count 0 right after the B-th frame ends. With B=0, frames repeat without end.
- R7: After a finite burst completes, the block stays in IDLE, ignoring sync, while `enable` stays high. It arms again only after `enable` is cleared and set.
- R8: With `sync_restart_en` high, a sync pulse in WAITING or RUNNING sets the count to 0 without changing the phase, and a restarted frame is not counted toward the burst. With the bit low, such a pulse has no effect.
- R9: Clearing `enable` in any phase gives IDLE and a count of 0 on the next clock.
- R10: `cfg_wr` loads the delay, frame length and burst count only while `enable` is low. A write while `enable` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms the sequencer; low forces IDLE |
| sync_pulse | input | 1 | One-cycle sync event |
| sync_restart_en | input | 1 | Sync during delay or run restarts the count |
| cfg_wr | input | 1 | Load strobe for the configuration values |
| cfg_delay_in | input | CNT_W | Startup delay in cycles |
| cfg_frame_len_in | input | CNT_W | Last count value of a frame |
| cfg_burst_in | input | BURST_W | Frames per burst, 0 = continuous |
| state_o | output | 2 | Phase code |
| frame_cnt_o | output | CNT_W | Delay or frame counter value |
| frame_start_o | output | 1 | High on the first cycle of a frame |
| frame_end_o | output | 1 | High on the last cycle of a frame |

## Verification
The main sequence is swept over every combination of delay, frame length and burst count from 0 to 3. Each cycle is compared with a phase and count computed from the elapsed time. This separates the one-cycle zero-delay case from a delay of one, a single-cycle frame from longer ones, and continuous running from finite bursts. Separate patterns send a sync in idle, in a finished burst and during delay or run, each with the restart bit on and off. This shows that the restart acts only when selected. A configuration write issued while enabled must leave the following frame timing unchanged.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARMED   = 2'd1,
    PH_WAITING = 2'd2,
    PH_RUNNING = 2'd3
  } phase_t;
endpackage

// File: rtl/tdd_cfg_shadow.sv
module tdd_cfg_shadow #(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               wr,
  input  logic [CNT_W-1:0]   delay_in,
  input  logic [CNT_W-1:0]   len_in,
  input  logic [BURST_W-1:0] burst_in,
  output logic [CNT_W-1:0]   delay_q,
  output logic [CNT_W-1:0]   len_q,
  output logic [BURST_W-1:0] burst_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q <= '0;
      len_q   <= '0;
      burst_q <= '0;
    end else if (wr && !enable) begin
      delay_q <= delay_in;
      len_q   <= len_in;
      burst_q <= burst_in;
    end
  end

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(len_q) && $stable(delay_q) && $stable(burst_q)));
endmodule

// File: rtl/tdd_burst_tally.sv
module tdd_burst_tally #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               frame_done,
  input  logic [BURST_W-1:0] burst,
  output logic               last_frame
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);
  logic [BURST_W-1:0] tally;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) tally <= '0;
    else if (frame_done && burst != '0) tally <= tally + ONE;
  end

  assign last_frame = (burst != '0) && (tally == burst - ONE);

  // R6
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst != '0 && !clear) |-> (tally < burst));
endmodule

// File: rtl/tdd_seq_ctrl.sv
module tdd_seq_ctrl
  import tdd_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_pulse,
  input  logic             sync_restart_en,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             last_frame,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_start,
  output logic             frame_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic finished;
  logic restart;
  logic last_wait;

  assign restart     = sync_pulse && sync_restart_en;
  assign last_wait   = (delay == '0) || (cnt == delay - ONE);
  assign frame_start = (phase == PH_RUNNING) && (cnt == '0);
  assign frame_end   = (phase == PH_RUNNING) && (cnt == frame_len) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      finished <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (!finished) phase <= PH_ARMED;
        end
        PH_ARMED: begin
          cnt <= '0;
          if (sync_pulse) phase <= PH_WAITING;
        end
        PH_WAITING: begin
          if (restart) cnt <= '0;
          else if (last_wait) begin
            phase <= PH_RUNNING;
            cnt   <= '0;
          end else cnt <= cnt + ONE;
        end
        PH_RUNNING: begin
          if (restart) cnt <= '0;
          else if (cnt == frame_len) begin
            cnt <= '0;
            if (last_frame) begin
              phase    <= PH_IDLE;
              finished <= 1'b1;
            end
          end else cnt <= cnt + ONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == PH_IDLE && cnt == '0));
  // R2
  arm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !enable) |=> phase != PH_ARMED);
  // R3
  wait_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && !sync_pulse) |=> phase != PH_WAITING);
  // R4
  run_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNNING) |-> cnt <= frame_len);
  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && restart && (phase == PH_WAITING || phase == PH_RUNNING))
      |=> (cnt == '0 && $stable(phase)));
endmodule

// File: rtl/tdd_frame_seq.sv
module tdd_frame_seq
  import tdd_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sync_pulse,
  input  logic               sync_restart_en,
  input  logic               cfg_wr,
  input  logic [CNT_W-1:0]   cfg_delay_in,
  input  logic [CNT_W-1:0]   cfg_frame_len_in,
  input  logic [BURST_W-1:0] cfg_burst_in,
  output logic [1:0]         state_o,
  output logic [CNT_W-1:0]   frame_cnt_o,
  output logic               frame_start_o,
  output logic               frame_end_o
);
  logic [CNT_W-1:0]   delay_q, len_q;
  logic [BURST_W-1:0] burst_q;
  logic               last_frame;
  phase_t             phase;

  tdd_cfg_shadow #(.CNT_W(CNT_W), .BURST_W(BURST_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr(cfg_wr),
    .delay_in(cfg_delay_in), .len_in(cfg_frame_len_in), .burst_in(cfg_burst_in),
    .delay_q(delay_q), .len_q(len_q), .burst_q(burst_q));

  tdd_burst_tally #(.BURST_W(BURST_W)) tally_i (
    .clk(clk), .rst_n(rst_n), .clear(phase != PH_RUNNING),
    .frame_done(frame_end_o), .burst(burst_q), .last_frame(last_frame));

  tdd_seq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_pulse(sync_pulse),
    .sync_restart_en(sync_restart_en), .delay(delay_q), .frame_len(len_q),
    .last_frame(last_frame), .phase(phase), .cnt(frame_cnt_o),
    .frame_start(frame_start_o), .frame_end(frame_end_o));

  assign state_o = phase;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && frame_end_o) |-> (len_q == '0));
endmodule

// File: tb/tdd_frame_seq_tb_top.sv
module tdd_frame_seq_tb_top;
  localparam int CW = 16;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, sync_pulse = 1'b0, sync_restart_en = 1'b0, cfg_wr = 1'b0;
  logic [CW-1:0] cfg_delay_in = '0, cfg_frame_len_in = '0;
  logic [BW-1:0] cfg_burst_in = '0;
  logic [1:0] state_o;
  logic [CW-1:0] frame_cnt_o;
  logic frame_start_o, frame_end_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tdd_frame_seq #(.CNT_W(CW), .BURST_W(BW)) dut_i (.*);

  task automatic check(string req, int st_e, int cnt_e, bit fs_e, bit fe_e);
    n_run++;
    if (int'(state_o) != st_e || int'(frame_cnt_o) != cnt_e ||
        frame_start_o != fs_e || frame_end_o != fe_e) begin
      n_fail++;
      $display("FAIL %s: got st=%0d cnt=%0d fs=%0b fe=%0b, exp st=%0d cnt=%0d fs=%0b fe=%0b",
               req, state_o, frame_cnt_o, frame_start_o, frame_end_o, st_e, cnt_e, fs_e, fe_e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_cfg(int d, int l, int b);
    enable = 1'b0;
    tick();
    cfg_delay_in = CW'(d); cfg_frame_len_in = CW'(l); cfg_burst_in = BW'(b);
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  // Runs one sequence from arming; lwr: a write attempted while enabled
  task automatic run_seq(string req, int d, int l, int b, bit lwr);
    int w, p, total;
    enable = 1'b1;
    if (lwr) begin
      cfg_frame_len_in = CW'(l + 4); cfg_delay_in = CW'(d + 2); cfg_wr = 1'b1;
    end
    tick();
    cfg_wr = 1'b0;
    check("R2 arm", 1, 0, 0, 0);
    sync_pulse = 1'b1;
    w = (d == 0) ? 1 : d;
    p = l + 1;
    total = w + p * ((b == 0) ? 3 : b) + 2;
    for (int n = 0; n < total; n++) begin
      int est, ecnt, m, idx;
      tick();
      sync_pulse = 1'b0;
      if (n < w) begin est = 2; ecnt = n; end
      else begin
        m = n - w; idx = m / p;
        if (b != 0 && idx >= b) begin est = 0; ecnt = 0; end
        else begin est = 3; ecnt = m % p; end
      end
      check(req, est, ecnt, est == 3 && ecnt == 0, est == 3 && ecnt == l);
    end
    if (b != 0) begin
      sync_pulse = 1'b1;
      tick();
      sync_pulse = 1'b0;
      tick();
      check("R7 finished stays idle", 0, 0, 0, 0);
    end
    enable = 1'b0;
    tick();
    check("R9 disable", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset", 0, 0, 0, 0);
    // R2: sync while idle and disabled is ignored
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0; tick();
    check("R2 idle sync", 0, 0, 0, 0);

    // R3 R4 R5 R6: near-exhaustive sweep
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < 4; l++)
        for (int b = 0; b < 4; b++) begin
          load_cfg(d, l, b);
          run_seq("R3/R4/R5/R6 sweep", d, l, b, 1'b0);
        end

    // R10: write while enabled ignored
    load_cfg(0, 2, 1);
    run_seq("R10 locked cfg", 0, 2, 1, 1'b1);
    // R7: re-arms after enable toggle
    enable = 1'b1; tick();
    check("R7 rearm", 1, 0, 0, 0);
    enable = 1'b0; tick();

    // R8: restart on sync
    load_cfg(3, 5, 0);
    sync_restart_en = 1'b1;
    enable = 1'b1; tick();
    check("R2 arm hold", 1, 0, 0, 0);
    tick();
    check("R2 arm waits", 1, 0, 0, 0);
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    check("R8 wait0", 2, 0, 0, 0);
    tick(); check("R8 wait1", 2, 1, 0, 0);
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    check("R8 restart in wait", 2, 0, 0, 0);
    tick(); check("R8 wait1b", 2, 1, 0, 0);
    tick(); check("R8 wait2b", 2, 2, 0, 0);
    tick(); check("R8 run0", 3, 0, 1, 0);
    tick(); check("R8 run1", 3, 1, 0, 0);
    tick(); check("R8 run2", 3, 2, 0, 0);
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    check("R8 restart in run", 3, 0, 1, 0);
    tick(); check("R8 run1b", 3, 1, 0, 0);
    sync_restart_en = 1'b0; sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    check("R8 no restart when off", 3, 2, 0, 0);
    tick(); tick(); tick();
    check("R5 frame end", 3, 5, 0, 1);
    tick(); check("R4 wrap", 3, 0, 1, 0);
    enable = 1'b0; tick();
    check("R9 disable in run", 0, 0, 0, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule